// File: doc/BRIEF.md
# Multi-Format Serial Audio Formatter

This block turns a stereo pair of parallel PCM samples into a one-wire serial stream with its own bit clock and word clock. Everything runs from a single master clock at 512 times the sample rate (nominally 44.1 kHz). Each audio frame lasts exactly 512 master cycles. A 2-bit format code selects one of four frame layouts. Three layouts use 48 bit clocks per frame and right-align a 16-, 18- or 20-bit word against the word-clock transition. The fourth uses 64 bit clocks per frame and left-aligns a 16-bit word one bit after the transition.

The source presents 16-bit samples with a one-cycle valid strobe at any time. The most recent strobed pair is taken at the start of each frame. If nothing new arrived, the previous pair is sent again. The format code is also taken only at frame starts, so a frame is always emitted whole in one layout. Data is sent MSB first and changes on the falling bit-clock edge, so a receiver samples it on the rising edge.

Top module: `serial_audio_fmt`

## Requirements
- R1: A frame spans exactly 512 master cycles. The word clock rises at the start of a frame, stays high for the left half-frame and stays low for the right half-frame. The two halves hold the same number of bit-clock periods.
- R2: Format code 0 gives 48 bit clocks per frame with 24 slots per half. The 16-bit sample fills the last 16 slots, MSB first. The first 8 slots repeat the sample's sign bit.
- R3: Format code 1 gives 48 bit clocks per frame. The half carries the 18-bit word {sample, 00} in its last 18 slots, so the two final slots are always 0. The 6 leading slots repeat the sign bit.
- R4: Format code 2 gives 48 bit clocks per frame. The half carries the 20-bit word {sample, 0000} in its last 20 slots, so the four final slots are always 0. The 4 leading slots repeat the sign bit.
- R5: Format code 3 gives 64 bit clocks per frame with 32 slots per half. Slot 0 is 0, slots 1 to 16 carry the sample MSB first, and slots 17 to 31 are 0.
- R6: In the 48-slot formats the bit-clock period is 10 or 11 master cycles. In the 64-slot format it is exactly 8 master cycles. Every bit-clock period starts with its low phase.
- R7: The serial data and the word clock change only in a cycle where the bit clock falls.
- R8: A new format code is applied only at the next frame start. The frame in progress keeps its layout to the end.
- R9: At each frame start the block takes the most recently strobed sample pair, with the last strobe winning. If no strobe arrived during the previous frame, the pair is repeated. A strobe in the last cycle of a frame counts toward the frame after next.
- R10: While reset is asserted, all three outputs are low. The first frame after reset uses format code 0 with zero samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 512 times the sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_i | input | 2 | Frame layout code (0 to 3) |
| valid_i | input | 1 | One-cycle strobe that captures left_i and right_i |
| left_i | input | SW | Left-channel sample, two's complement |
| right_i | input | SW | Right-channel sample, two's complement |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock, high during the left half-frame |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
On every cycle the embedded assertions check four things:
- the frame counter wrap;
- that the format code and the sample pair are loaded only at frame starts;
- the forced-zero tail slots of the 18- and 20-bit layouts and the empty first slot of the 64-slot layout;
- that data and word-clock changes coincide with a falling bit clock.

Some properties can only be shown by the bench acting as a receiver: frame length, bit counts per half, bit-clock periods, and the full slot contents. It does this over a sweep of every format with walking-bit samples, with formats changed and samples strobed mid-frame (twice, so the last strobe must win) and once not strobed at all.

// File: rtl/saf_pkg.sv
package saf_pkg;

  // Frame layout codes; the numeric values are the external format select.
  typedef enum logic [1:0] {
    FMT_R16  = 2'b00,  // 48 slots, 16-bit word right-aligned
    FMT_R18  = 2'b01,  // 48 slots, 18-bit word right-aligned, 2 zero LSBs
    FMT_R20  = 2'b10,  // 48 slots, 20-bit word right-aligned, 4 zero LSBs
    FMT_L16D = 2'b11   // 64 slots, 16-bit word left-aligned, one slot late
  } fmt_e;

  localparam int FRAME_CYC = 512;               // master cycles per frame
  localparam int CNT_W     = $clog2(FRAME_CYC); // frame counter width
  localparam int SLOT_W    = 6;                 // slot index width (max 64)
  localparam int NB_W      = SLOT_W + 1;        // width holding a slot count

  function automatic int slots_per_frame(input fmt_e f);
    return (f == FMT_L16D) ? 64 : 48;
  endfunction

  function automatic int half_of(input fmt_e f);
    return slots_per_frame(f) / 2;
  endfunction

  // Zero bits appended below the sample to widen it to the word size.
  function automatic int pad_of(input fmt_e f);
    case (f)
      FMT_R18: return 2;
      FMT_R20: return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/saf_frame_timer.sv
module saf_frame_timer
  import saf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_end_o
);

  logic [CNT_W-1:0] cnt_q;

  assign frame_end_o = (cnt_q == CNT_W'(FRAME_CYC - 1));
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (frame_end_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (cnt_q == '0)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_o |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

endmodule

// File: rtl/saf_capture.sv
module saf_capture
  import saf_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end_i,
  input  logic [1:0]    fmt_i,
  input  logic          valid_i,
  input  logic [SW-1:0] left_i,
  input  logic [SW-1:0] right_i,
  output fmt_e          fmt_o,
  output logic [SW-1:0] act_l_o,
  output logic [SW-1:0] act_r_o
);

  logic [SW-1:0] pend_l_q, pend_r_q;
  logic [SW-1:0] act_l_q,  act_r_q;
  fmt_e          fmt_q;

  // Holding registers: the last strobe wins until the frame start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
    end else if (valid_i) begin
      pend_l_q <= left_i;
      pend_r_q <= right_i;
    end
  end

  // Frame-start loading of the pair and the layout.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_l_q <= '0;
      act_r_q <= '0;
      fmt_q   <= FMT_R16;
    end else if (frame_end_i) begin
      act_l_q <= pend_l_q;
      act_r_q <= pend_r_q;
      fmt_q   <= fmt_e'(fmt_i);
    end
  end

  assign fmt_o   = fmt_q;
  assign act_l_o = act_l_q;
  assign act_r_o = act_r_q;

  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> $stable(fmt_q)); // R8

  AST_FMT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> (fmt_q == fmt_e'($past(fmt_i)))); // R8

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> ($stable(act_l_q) && $stable(act_r_q))); // R9

  AST_PAIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> (act_l_q == $past(pend_l_q) && act_r_q == $past(pend_r_q))); // R9

endmodule

// File: rtl/saf_slot_gen.sv
module saf_slot_gen
  import saf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  fmt_e             fmt_i,
  output logic [SLOT_W-1:0] pos_o,
  output logic             right_o,
  output logic             bclk_lvl_o
);

  localparam int PW = CNT_W + NB_W;

  logic [NB_W-1:0]   nslots;
  logic [NB_W-1:0]   nhalf;
  logic [PW-1:0]     prod;
  logic [SLOT_W-1:0] slot;

  // slot = floor(cnt * slots / FRAME_CYC); the bit below the slot field is
  // the phase: low in the first half of a slot, high in the second.
  assign nslots     = NB_W'(slots_per_frame(fmt_i));
  assign nhalf      = NB_W'(half_of(fmt_i));
  assign prod       = PW'(cnt_i) * PW'(nslots);
  assign slot       = prod[CNT_W +: SLOT_W];
  assign bclk_lvl_o = prod[CNT_W-1];
  assign right_o    = (NB_W'(slot) >= nhalf);
  assign pos_o      = right_o ? SLOT_W'(NB_W'(slot) - nhalf) : slot;

  AST_POS_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (NB_W'(pos_o) < nhalf)); // R1

endmodule

// File: rtl/saf_serializer.sv
module saf_serializer
  import saf_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt_i,
  input  logic [SLOT_W-1:0] pos_i,
  input  logic              right_i,
  input  logic              bclk_lvl_i,
  input  logic [SW-1:0]     act_l_i,
  input  logic [SW-1:0]     act_r_i,
  output logic              bclk_o,
  output logic              wclk_o,
  output logic              sdata_o
);

  // Bit carried by slot p of a half-frame for sample s in layout f.
  function automatic logic pick_bit(input logic [SW-1:0] s, input fmt_e f, input int p);
    int hs, pad, w, lead, idx;
    hs  = half_of(f);
    pad = pad_of(f);
    if (f == FMT_L16D) begin
      if (p >= 1 && p <= SW) return s[SW-p];
      return 1'b0;
    end
    w    = SW + pad;
    lead = hs - w;
    if (p < lead) return s[SW-1];
    idx = w - 1 - (p - lead);
    if (idx < pad) return 1'b0;
    return s[idx-pad];
  endfunction

  logic [SW-1:0] smp;
  logic          bit_nxt;
  logic [1:0]    live_q;

  assign smp     = right_i ? act_r_i : act_l_i;
  assign bit_nxt = pick_bit(smp, fmt_i, int'(pos_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_o  <= 1'b0;
      wclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      live_q  <= 2'b00;
    end else begin
      bclk_o  <= bclk_lvl_i;
      wclk_o  <= ~right_i;
      sdata_o <= bit_nxt;
      live_q  <= {live_q[0], 1'b1};
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (!bclk_o && !wclk_o && !sdata_o)); // R10

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n || !live_q[1])
    !$stable(sdata_o) |-> $fell(bclk_o)); // R7

  AST_WCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n || !live_q[1])
    !$stable(wclk_o) |-> $fell(bclk_o)); // R7

  AST_PAD18_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == FMT_R18 && int'(pos_i) >= half_of(FMT_R18) - pad_of(FMT_R18)) |-> !bit_nxt); // R3

  AST_PAD20_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == FMT_R20 && int'(pos_i) >= half_of(FMT_R20) - pad_of(FMT_R20)) |-> !bit_nxt); // R4

  AST_LATE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == FMT_L16D && pos_i == '0) |-> !bit_nxt); // R5

endmodule

// File: rtl/serial_audio_fmt.sv
module serial_audio_fmt
  import saf_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt_i,
  input  logic          valid_i,
  input  logic [SW-1:0] left_i,
  input  logic [SW-1:0] right_i,
  output logic          bclk_o,
  output logic          wclk_o,
  output logic          sdata_o
);

  logic [CNT_W-1:0]  cnt;
  logic              frame_end;
  fmt_e              fmt_act;
  logic [SW-1:0]     act_l, act_r;
  logic [SLOT_W-1:0] pos;
  logic              right_half;
  logic              bclk_lvl;

  saf_frame_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_o       (cnt),
    .frame_end_o (frame_end)
  );

  saf_capture #(.SW(SW)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_end_i (frame_end),
    .fmt_i       (fmt_i),
    .valid_i     (valid_i),
    .left_i      (left_i),
    .right_i     (right_i),
    .fmt_o       (fmt_act),
    .act_l_o     (act_l),
    .act_r_o     (act_r)
  );

  saf_slot_gen u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt),
    .fmt_i      (fmt_act),
    .pos_o      (pos),
    .right_o    (right_half),
    .bclk_lvl_o (bclk_lvl)
  );

  saf_serializer #(.SW(SW)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_i      (fmt_act),
    .pos_i      (pos),
    .right_i    (right_half),
    .bclk_lvl_i (bclk_lvl),
    .act_l_i    (act_l),
    .act_r_i    (act_r),
    .bclk_o     (bclk_o),
    .wclk_o     (wclk_o),
    .sdata_o    (sdata_o)
  );

endmodule

// File: tb/test_serial_audio_fmt.sv
module test_serial_audio_fmt;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt;
  logic        valid;
  logic [15:0] l_in, r_in;
  logic        bclk, wclk, sd;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic pb, pw, ps;
  int lastrise;

  always #5 clk = ~clk;

  serial_audio_fmt #(.SW(16)) i_serial_audio_fmt (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .valid_i(valid),
    .left_i(l_in), .right_i(r_in),
    .bclk_o(bclk), .wclk_o(wclk), .sdata_o(sd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Expected half-frame contents, first slot in the top bit.
  function automatic logic [31:0] exp_half(input logic [1:0] f, input logic [15:0] s);
    logic signed [31:0] x;
    if (f == 2'b11) return {1'b0, s, 15'b0};
    x = {{16{s[15]}}, s};
    x = x <<< (2 * int'(f));
    return x;
  endfunction

  function automatic string req_of(input logic [1:0] f);
    case (f)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Receives one frame (called just after a word-clock rise was seen) and
  // drives the inputs for the following frame in its middle.
  task automatic run_frame(input logic [1:0] ef, input logic [15:0] el, input logic [15:0] er,
                           input logic [1:0] nf, input logic [15:0] nl, input logic [15:0] nr,
                           input bit strobe, input string tag);
    int n = 0, h, lc = 0, rc = 0, perr = 0, eerr = 0;
    logic [63:0] lw = '0, rw = '0, mask, xl, xr;
    bit done = 0;
    logic b, w, d;
    h = (ef == 2'b11) ? 32 : 24;
    lastrise = -1;
    while (!done && n < 700) begin
      @(negedge clk);
      n++;
      if (n == 200) begin
        fmt = nf; l_in = ~nl; r_in = ~nr; valid = strobe;
      end else if (n == 300) begin
        l_in = nl; r_in = nr; valid = strobe;
      end else if (n == 301) begin
        valid = 1'b0; l_in = 16'hDEAD; r_in = 16'hBEEF;
      end else begin
        valid = 1'b0;
      end
      b = bclk; w = wclk; d = sd;
      if ((w !== pw || d !== ps) && !(pb && !b)) eerr++;
      if (b && !pb) begin
        if (lastrise >= 0) begin
          int per;
          per = n - lastrise;
          if (ef == 2'b11 ? (per != 8) : (per < 10 || per > 11)) perr++;
        end
        lastrise = n;
        if (w) begin lw = {lw[62:0], d}; lc++; end
        else   begin rw = {rw[62:0], d}; rc++; end
      end
      if (w && !pw) done = 1;
      pb = b; pw = w; ps = d;
    end
    mask = (64'h1 << h) - 1;
    xl = {32'b0, exp_half(ef, el)} & mask;
    xr = {32'b0, exp_half(ef, er)} & mask;
    check(n == 512, "R1", {tag, " frame length"}, n, 512);
    check(lc == h && rc == h, req_of(ef), {tag, " slots per half"}, lc * 100 + rc, h * 100 + h);
    check((lw & mask) == xl, req_of(ef), {tag, " left half"}, lw & mask, xl);
    check((rw & mask) == xr, req_of(ef), {tag, " right half"}, rw & mask, xr);
    check(perr == 0, "R6", {tag, " bit clock periods"}, perr, 0);
    check(eerr == 0, "R7", {tag, " changes off falling edge"}, eerr, 0);
  endtask

  initial begin
    logic [1:0]  cf;
    logic [15:0] cl, cr;
    bit found;
    rst_n = 1'b0; fmt = 2'b00; valid = 1'b0; l_in = '0; r_in = '0;
    repeat (4) @(negedge clk);
    check({bclk, wclk, sd} == 3'b000, "R10", "outputs in reset", {bclk, wclk, sd}, 0);
    pb = 1'b0; pw = 1'b0; ps = 1'b0;
    rst_n = 1'b1;
    found = 0;
    for (int i = 0; i < 20 && !found; i++) begin
      @(negedge clk);
      if (wclk && !pw) found = 1;
      pb = bclk; pw = wclk; ps = sd;
    end
    check(found, "R1", "word clock rises after reset", found, 1);

    // R10: first frame is format 0 with zero samples.
    run_frame(2'd0, 16'h0000, 16'h0000, 2'd0, 16'h1234, 16'h8001, 1, "R10 first");
    run_frame(2'd0, 16'h1234, 16'h8001, 2'd1, 16'hF00F, 16'h7FFF, 1, "R9 last strobe R8");
    run_frame(2'd1, 16'hF00F, 16'h7FFF, 2'd2, 16'hA5A5, 16'h5A5A, 1, "R8 switch");
    run_frame(2'd2, 16'hA5A5, 16'h5A5A, 2'd3, 16'h8000, 16'h0001, 1, "R8 switch");
    run_frame(2'd3, 16'h8000, 16'h0001, 2'd3, 16'h1111, 16'h2222, 0, "R9 no strobe");
    run_frame(2'd3, 16'h8000, 16'h0001, 2'd0, 16'hFFFF, 16'h0000, 1, "R9 repeat");
    cf = 2'd0; cl = 16'hFFFF; cr = 16'h0000;

    // Sweep every layout with walking-bit samples of both signs.
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 8; k++) begin
        logic [15:0] nl, nr;
        nl = 16'(32'h1 << (2 * k)) | (k[0] ? 16'h8000 : 16'h0000);
        nr = ~nl ^ 16'(k);
        run_frame(cf, cl, cr, 2'(f), nl, nr, 1, "sweep");
        cf = 2'(f); cl = nl; cr = nr;
      end
    end
    run_frame(cf, cl, cr, 2'd0, 16'h0000, 16'h0000, 1, "final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule